// File: doc/BRIEF.md
# Supply Supervisor with Hysteresis

This block watches a digitised supply voltage. Upstream measurement logic delivers the voltage as an unsigned millivolt code together with a one-cycle sample strobe. From each sample the block decides three things: whether the chip must be held in reset because the supply is too low for any operation, whether a selectable brownout level has been crossed, and whether a software-programmable warning level has been crossed. Each of the three monitors has its own hysteresis band, so a supply that hovers near a threshold does not make the outputs chatter.

The two reset monitors drive one reset output. That output asserts in the same cycle in which either monitor sees the supply fall too low. It releases only after a fixed count of clock cycles in which neither monitor has requested reset. The warning monitor drives a level output and a one-cycle interrupt pulse. The pulse can be enabled separately for the output's rising edge and for its falling edge. The brownout level comes from a static configuration input that is loaded from non-volatile settings.

Top module: `supply_supervisor`

## Requirements
- R1: A sample below `PDR_MV` (default 1800 mV) sets `rstOut` to 1 in the cycle after the strobe edge.
- R2: Once the power-down monitor is tripping, it stops requesting reset only when a sample is at least `PDR_MV + POR_HYST` (default 1840 mV). A sample in the band between the two thresholds leaves its state unchanged.
- R3: When neither reset monitor requests reset any longer, `rstOut` stays 1 for exactly `TEMPO_CYC` further clock edges and then falls to 0.
- R4: A new reset request during the release delay restarts the delay, so the full `TEMPO_CYC` count applies again after that request clears.
- R5: `borSel` = 00 turns the brownout monitor off, and its state clears on the next clock. With the monitor off, only the power-down monitor controls `rstOut`. Codes 01, 10 and 11 select falling levels `BOR_L1_MV`, `BOR_L2_MV` and `BOR_L3_MV` (defaults 2200, 2500 and 2800 mV). Each level releases at that level + 100 mV.
- R6: `pvdLevel` selects the warning threshold: 0→2000, 1→2100, 2→2300, 3→2500, 4→2600, 5→2700, 6→2800, 7→2900 mV.
- R7: `pvdOut` is 1 after a sample below the selected threshold and 0 after a sample at or above the threshold + 100 mV. A sample between those two values leaves it unchanged. A sample exactly at the threshold does not set it.
- R8: While `pvdEn` is 0, `pvdOut` is 0 from the next clock and ignores samples. After `pvdEn` returns to 1, it stays 0 until the next sample.
- R9: `pvdIrq` pulses high for one cycle, one clock after `pvdOut` changes. A 0→1 change pulses only if `irqRiseEn` is set, and a 1→0 change pulses only if `irqFallEn` is set.
- R10: During and right after reset, `rstOut` = 1, `pvdOut` = 0 and `pvdIrq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | One-cycle strobe marking a new voltage sample |
| supplyMv | input | 13 | Supply voltage in millivolts |
| borSel | input | 2 | Brownout level select, 00 = off |
| pvdEn | input | 1 | Warning monitor enable |
| pvdLevel | input | 3 | Warning threshold code |
| irqRiseEn | input | 1 | Interrupt on warning output rising edge |
| irqFallEn | input | 1 | Interrupt on warning output falling edge |
| rstOut | output | 1 | Chip reset request, active high |
| pvdOut | output | 1 | Warning output, 1 = supply below threshold |
| pvdIrq | output | 1 | One-cycle warning edge interrupt |

## Verification
Every internal fault in this block shows up on one of the three outputs. A corrupted hysteresis flag changes `rstOut` or `pvdOut` in the cycle right after the sample that should have left the flag alone. A wrong release counter moves the falling edge of `rstOut` away from exactly `TEMPO_CYC` edges after the last request. That error is only visible when the release finally happens, so the bench counts every cycle of the delay. A stale edge register shows as a missing, extra or late `pvdIrq` pulse one cycle after the level change.

// File: rtl/supsup_pkg.sv
`timescale 1ns/1ps
package supsup_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleStb;
    logic borOff;
    logic pvdOff;
  } dpStrobe_t;

  // monitor states from datapath to control
  typedef struct packed {
    logic porLow;
    logic borLow;
    logic pvdLow;
  } dpStatus_t;

  localparam int NUM_MON = 3;
  localparam int MON_POR = 0;
  localparam int MON_BOR = 1;
  localparam int MON_PVD = 2;

endpackage

// File: rtl/supsup_hyst_cell.sv
`timescale 1ns/1ps
module supsup_hyst_cell #(
  parameter int MV_W     = 13,
  parameter int HYST_MV  = 100,
  parameter bit INIT_LOW = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleStb,
  input  logic            forceClr,
  input  logic [MV_W-1:0] fallMv,
  input  logic [MV_W-1:0] supplyMv,
  output logic            belowQ
);
  localparam int EXT_W = MV_W + 1;

  logic [EXT_W-1:0] riseMv;
  logic goLow, goHigh;

  assign riseMv = {1'b0, fallMv} + EXT_W'(HYST_MV);
  assign goLow  = supplyMv < fallMv;
  assign goHigh = {1'b0, supplyMv} >= riseMv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            belowQ <= INIT_LOW;
    else if (forceClr)     belowQ <= 1'b0;
    else if (sampleStb) begin
      if (goLow)           belowQ <= 1'b1;
      else if (goHigh)     belowQ <= 1'b0;
    end
  end

  // R2 / R7: a sample inside the band keeps the state
  a_r7_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && !forceClr && !goLow && !goHigh) |=> (belowQ == $past(belowQ)));

  // R1 / R7: a sample under the falling threshold trips the monitor
  a_r1_trip_below: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && !forceClr && (supplyMv < fallMv)) |=> belowQ);
endmodule

// File: rtl/supsup_datapath.sv
`timescale 1ns/1ps
module supsup_datapath
  import supsup_pkg::*;
#(
  parameter int MV_W      = 13,
  parameter int PDR_MV    = 1800,
  parameter int POR_HYST  = 40,
  parameter int BOR_L1_MV = 2200,
  parameter int BOR_L2_MV = 2500,
  parameter int BOR_L3_MV = 2800,
  parameter int BOR_HYST  = 100,
  parameter int PVD_HYST  = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] supplyMv,
  input  logic [1:0]      borSel,
  input  logic [2:0]      pvdLevel,
  input  dpStrobe_t       strobe,
  output dpStatus_t       status
);
  localparam int HYST_TAB [NUM_MON] = '{POR_HYST, BOR_HYST, PVD_HYST};
  localparam bit INIT_TAB [NUM_MON] = '{1'b1, 1'b1, 1'b0};

  logic [MV_W-1:0] fallTab [NUM_MON];
  logic            clrTab  [NUM_MON];
  logic            lowTab  [NUM_MON];
  logic [MV_W-1:0] borFall, pvdFall;

  always_comb begin
    unique case (borSel)
      2'b01:   borFall = MV_W'(BOR_L1_MV);
      2'b10:   borFall = MV_W'(BOR_L2_MV);
      default: borFall = MV_W'(BOR_L3_MV);
    endcase
  end

  always_comb begin
    unique case (pvdLevel)
      3'd0: pvdFall = MV_W'(2000);
      3'd1: pvdFall = MV_W'(2100);
      3'd2: pvdFall = MV_W'(2300);
      3'd3: pvdFall = MV_W'(2500);
      3'd4: pvdFall = MV_W'(2600);
      3'd5: pvdFall = MV_W'(2700);
      3'd6: pvdFall = MV_W'(2800);
      default: pvdFall = MV_W'(2900);
    endcase
  end

  assign fallTab[MON_POR] = MV_W'(PDR_MV);
  assign fallTab[MON_BOR] = borFall;
  assign fallTab[MON_PVD] = pvdFall;
  assign clrTab[MON_POR]  = 1'b0;
  assign clrTab[MON_BOR]  = strobe.borOff;
  assign clrTab[MON_PVD]  = strobe.pvdOff;

  for (genvar i = 0; i < NUM_MON; i++) begin : g_mon
    supsup_hyst_cell #(
      .MV_W(MV_W), .HYST_MV(HYST_TAB[i]), .INIT_LOW(INIT_TAB[i])
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .sampleStb(strobe.sampleStb),
      .forceClr(clrTab[i]), .fallMv(fallTab[i]), .supplyMv(supplyMv),
      .belowQ(lowTab[i])
    );
  end

  assign status.porLow = lowTab[MON_POR];
  assign status.borLow = lowTab[MON_BOR];
  assign status.pvdLow = lowTab[MON_PVD];

  // R5: brownout state cleared once the monitor is off
  a_r5_bor_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.borOff |=> !status.borLow);

  // R8: warning state cleared while disabled
  a_r8_pvd_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pvdOff |=> !status.pvdLow);
endmodule

// File: rtl/supsup_control.sv
`timescale 1ns/1ps
module supsup_control
  import supsup_pkg::*;
#(
  parameter int TEMPO_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleValid,
  input  logic [1:0] borSel,
  input  logic       pvdEn,
  input  logic       irqRiseEn,
  input  logic       irqFallEn,
  input  dpStatus_t  status,
  output dpStrobe_t  strobe,
  output logic       rstOut,
  output logic       pvdOut,
  output logic       pvdIrq
);
  localparam int CNT_W = $clog2(TEMPO_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TEMPO_CYC - 1);

  logic             holdReq;
  logic             pendQ;
  logic [CNT_W-1:0] cntQ;
  logic             pvdPrevQ;

  assign strobe.sampleStb = sampleValid;
  assign strobe.borOff    = (borSel == 2'b00);
  assign strobe.pvdOff    = !pvdEn;

  assign holdReq = status.porLow | status.borLow;
  assign rstOut  = holdReq | pendQ;
  assign pvdOut  = status.pvdLow;

  // release temporization
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= 1'b1;
      cntQ  <= '0;
    end else if (holdReq) begin
      pendQ <= 1'b1;
      cntQ  <= '0;
    end else if (pendQ) begin
      if (cntQ == CNT_LAST) pendQ <= 1'b0;
      else                  cntQ  <= cntQ + 1'b1;
    end
  end

  // edge interrupt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvdPrevQ <= 1'b0;
      pvdIrq   <= 1'b0;
    end else begin
      pvdPrevQ <= status.pvdLow;
      pvdIrq   <= (status.pvdLow & ~pvdPrevQ & irqRiseEn) |
                  (~status.pvdLow & pvdPrevQ & irqFallEn);
    end
  end

  // R3: release only after the full count with no request
  a_r3_full_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pendQ) |-> ($past(cntQ) == CNT_LAST && !$past(holdReq)));

  // R4: a request restarts the count
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    holdReq |=> (cntQ == '0));

  // R9: a pulse only follows a change of the warning output
  a_r9_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    pvdIrq |-> (pvdPrevQ != $past(pvdPrevQ)));

  // R9: pulse direction matches its enable
  a_r9_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pvdIrq |-> (pvdPrevQ ? $past(irqRiseEn) : $past(irqFallEn)));
endmodule

// File: rtl/supply_supervisor.sv
`timescale 1ns/1ps
module supply_supervisor
  import supsup_pkg::*;
#(
  parameter int MV_W      = 13,
  parameter int TEMPO_CYC = 16,
  parameter int PDR_MV    = 1800,
  parameter int POR_HYST  = 40,
  parameter int BOR_L1_MV = 2200,
  parameter int BOR_L2_MV = 2500,
  parameter int BOR_L3_MV = 2800,
  parameter int BOR_HYST  = 100,
  parameter int PVD_HYST  = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleValid,
  input  logic [MV_W-1:0] supplyMv,
  input  logic [1:0]      borSel,
  input  logic            pvdEn,
  input  logic [2:0]      pvdLevel,
  input  logic            irqRiseEn,
  input  logic            irqFallEn,
  output logic            rstOut,
  output logic            pvdOut,
  output logic            pvdIrq
);
  dpStrobe_t strobe;
  dpStatus_t status;

  supsup_datapath #(
    .MV_W(MV_W), .PDR_MV(PDR_MV), .POR_HYST(POR_HYST),
    .BOR_L1_MV(BOR_L1_MV), .BOR_L2_MV(BOR_L2_MV), .BOR_L3_MV(BOR_L3_MV),
    .BOR_HYST(BOR_HYST), .PVD_HYST(PVD_HYST)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .supplyMv(supplyMv), .borSel(borSel),
    .pvdLevel(pvdLevel), .strobe(strobe), .status(status)
  );

  supsup_control #(.TEMPO_CYC(TEMPO_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .borSel(borSel),
    .pvdEn(pvdEn), .irqRiseEn(irqRiseEn), .irqFallEn(irqFallEn),
    .status(status), .strobe(strobe), .rstOut(rstOut), .pvdOut(pvdOut),
    .pvdIrq(pvdIrq)
  );
endmodule

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;
  localparam int TEMPO = 16;

  typedef struct packed {
    logic [2:0]  lvl;
    logic [12:0] mv;
    logic        exp;
  } vec_t;

  // R6 / R7: per code, just under the threshold trips, threshold + 100 releases
  localparam vec_t VEC [16] = '{
    '{3'd0, 13'd1999, 1'b1}, '{3'd0, 13'd2100, 1'b0},
    '{3'd1, 13'd2099, 1'b1}, '{3'd1, 13'd2200, 1'b0},
    '{3'd2, 13'd2299, 1'b1}, '{3'd2, 13'd2400, 1'b0},
    '{3'd3, 13'd2499, 1'b1}, '{3'd3, 13'd2600, 1'b0},
    '{3'd4, 13'd2599, 1'b1}, '{3'd4, 13'd2700, 1'b0},
    '{3'd5, 13'd2699, 1'b1}, '{3'd5, 13'd2800, 1'b0},
    '{3'd6, 13'd2799, 1'b1}, '{3'd6, 13'd2900, 1'b0},
    '{3'd7, 13'd2899, 1'b1}, '{3'd7, 13'd3000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleValid = 1'b0;
  logic [12:0] supplyMv = '0;
  logic [1:0] borSel = 2'b00;
  logic pvdEn = 1'b0;
  logic [2:0] pvdLevel = '0;
  logic irqRiseEn = 1'b0;
  logic irqFallEn = 1'b0;
  logic rstOut, pvdOut, pvdIrq;

  int checkCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.TEMPO_CYC(TEMPO)) uut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .supplyMv(supplyMv),
    .borSel(borSel), .pvdEn(pvdEn), .pvdLevel(pvdLevel),
    .irqRiseEn(irqRiseEn), .irqFallEn(irqFallEn),
    .rstOut(rstOut), .pvdOut(pvdOut), .pvdIrq(pvdIrq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // present one sample; returns 1 ns after the edge that captured it
  task automatic doSample(input int mv);
    supplyMv = 13'(mv);
    sampleValid = 1'b1;
    tick();
    sampleValid = 1'b0;
  endtask

  // rstOut high for TEMPO-1 more edges, low at the TEMPO-th
  task automatic checkRelease(input string req);
    for (int k = 1; k < TEMPO; k++) begin
      tick();
      check(req, rstOut, 1'b1);
    end
    tick();
    check(req, rstOut, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) tick();
    check("R10 rst", rstOut, 1'b1);
    check("R10 pvd", pvdOut, 1'b0);
    check("R10 irq", pvdIrq, 1'b0);
    rst_n = 1'b1;
    repeat (2) tick();
    check("R10 after", rstOut, 1'b1);

    // R3: release delay
    doSample(3300);
    check("R3 start", rstOut, 1'b1);
    checkRelease("R3");

    // R2 / R1: power-down band and trip
    doSample(1820);
    check("R2 band from high", rstOut, 1'b0);
    doSample(1799);
    check("R1 trip", rstOut, 1'b1);
    doSample(1839);
    tick();
    check("R2 band from low", rstOut, 1'b1);

    // R4: restart during delay
    doSample(1840);
    repeat (3) tick();
    check("R4 mid delay", rstOut, 1'b1);
    doSample(1700);
    check("R4 re-trip", rstOut, 1'b1);
    doSample(1900);
    checkRelease("R4");

    // R5: brownout levels
    doSample(2000);
    check("R5 off no effect", rstOut, 1'b0);
    borSel = 2'b10;
    doSample(2499);
    check("R5 L2 trip", rstOut, 1'b1);
    doSample(2599);
    tick();
    check("R5 L2 band", rstOut, 1'b1);
    doSample(2600);
    checkRelease("R5 L2");
    borSel = 2'b11;
    doSample(2799);
    check("R5 L3 trip", rstOut, 1'b1);
    borSel = 2'b01;
    doSample(2300);
    checkRelease("R5 L1 release");
    doSample(2199);
    check("R5 L1 trip", rstOut, 1'b1);
    borSel = 2'b00;
    repeat (TEMPO + 2) tick();
    check("R5 off releases", rstOut, 1'b0);

    // R6 / R7: threshold table
    pvdEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      pvdLevel = VEC[i].lvl;
      doSample(int'(VEC[i].mv));
      check("R6 table", pvdOut, VEC[i].exp);
    end

    // R7: boundaries and band
    pvdLevel = 3'd0;
    doSample(2000);
    check("R7 at threshold", pvdOut, 1'b0);
    doSample(1999);
    check("R7 below", pvdOut, 1'b1);
    doSample(2099);
    check("R7 band", pvdOut, 1'b1);
    doSample(2100);
    check("R7 release", pvdOut, 1'b0);

    // R9: edge interrupts
    irqRiseEn = 1'b1; irqFallEn = 1'b0;
    doSample(1999);
    check("R9 rise not yet", pvdIrq, 1'b0);
    tick();
    check("R9 rise pulse", pvdIrq, 1'b1);
    tick();
    check("R9 rise one cycle", pvdIrq, 1'b0);
    doSample(2100);
    tick();
    check("R9 fall masked", pvdIrq, 1'b0);
    irqRiseEn = 1'b0; irqFallEn = 1'b1;
    doSample(1999);
    tick();
    check("R9 rise masked", pvdIrq, 1'b0);
    doSample(2100);
    tick();
    check("R9 fall pulse", pvdIrq, 1'b1);
    irqRiseEn = 1'b1;
    doSample(1999);
    tick();
    check("R9 both rise", pvdIrq, 1'b1);
    irqRiseEn = 1'b0; irqFallEn = 1'b0;

    // R8: disable forces and holds 0
    pvdEn = 1'b0;
    tick();
    check("R8 forced", pvdOut, 1'b0);
    doSample(1500);
    check("R8 ignores sample", pvdOut, 1'b0);
    doSample(1999);
    check("R8 still 0", pvdOut, 1'b0);
    pvdEn = 1'b1;
    tick();
    check("R8 re-enabled no sample", pvdOut, 1'b0);
    doSample(1999);
    check("R8 next sample", pvdOut, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule